// File: doc/BRIEF.md
# Congestion-Aware Output Channel Arbiter

This block sits at one output channel of a router and chooses, every cycle, which of the virtual channels connected to that channel sends a flit. A VC can compete only when three things are true: it already holds a downstream VC, it has a flit waiting, and it has credit. Each VC also reports the direction its packet will take at the next router.

The contenders are split into classes by that next-hop direction, and each class has its own round-robin arbiter. Alongside these, a direction ranker orders the next-hop directions by per-direction congestion levels supplied by the neighbouring router. The ranker puts lightly loaded directions first and breaks ties between equal levels in round-robin order. The grant goes to the class winner of the best-ranked direction that has a contender.

Once a packet is granted, it keeps the channel on later cycles until its tail flit leaves or it stalls. This wormhole hold means body flits are never interleaved with flits from another packet. The grant is combinational from the inputs and the registered state. Pointers and the hold state change at the clock edge that follows a grant.

Top module: `cong_out_arb`

## Requirements
- R1: `grant_o` has at most one bit set. It is all-zero exactly when no VC is eligible.
- R2: VC v is eligible only when `vc_alloc_i[v]`, `vc_nonempty_i[v]` and `vc_credit_i[v]` are all 1. A VC missing any one of these is never granted.
- R3: VC v belongs to class d, where d is the 2-bit code in `vc_ndir_i[2v+1:2v]` (0 to 3). Within a class, the search for a winner starts at the VC after the last one granted from that class and wraps around. The class pointer starts at VC 0 and moves only when that class is granted.
- R4: When no hold is active, the grant goes to a class whose congestion level `dir_cong_i[2d+1:2d]` is the lowest among classes that have eligible VCs. Level 0 means lightly loaded; higher values mean more congested.
- R5: Classes with equal congestion levels are taken in round-robin order. The search starts at the direction after the one granted last, and starts at direction 0 after reset.
- R6: If a VC was granted and `vc_tail_i` for it was 0, that VC is granted again in the next cycle whenever it is still eligible. This holds regardless of congestion levels or other contenders.
- R7: A grant with `vc_tail_i` set ends the hold. A held VC that is no longer eligible also loses the hold. In that second case, fresh arbitration picks a grant in that same cycle.
- R8: During and right after reset, no hold is active and all pointers are at 0. With every VC eligible, every VC in class 0, and all levels equal, the first grant after reset is VC 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vc_alloc_i | input | NUM_VC | VC holds a downstream VC |
| vc_nonempty_i | input | NUM_VC | VC has a flit at its head |
| vc_credit_i | input | NUM_VC | Downstream credit available for the VC |
| vc_tail_i | input | NUM_VC | Head flit of the VC is a tail flit |
| vc_ndir_i | input | NUM_VC*DIR_W | Next-hop direction code per VC |
| dir_cong_i | input | NUM_DIR*CONG_W | Congestion level per next-hop direction |
| grant_o | output | NUM_VC | One-hot grant to the selected VC |

## Verification
A grant is due in the same cycle as the inputs that produce it. The bench drives inputs just after a rising edge and reads `grant_o` at the falling edge of that same cycle. Effects that carry over (class pointers, the direction pointer and the wormhole hold) show up in the grant of the next cycle. The behavioural model applies each sampled grant to its own state at the moment of sampling, so its prediction for the next cycle lines up with the registers the design loads at the intervening rising edge. Directed phases push eligibility gaps, distinct and equal congestion levels, long packets and frequent stalls through that single per-cycle comparison.

// File: rtl/cong_arb_pkg.sv
package cong_arb_pkg;
    localparam int unsigned DEF_NUM_VC  = 16;
    localparam int unsigned DEF_NUM_DIR = 4;
    localparam int unsigned DEF_CONG_W  = 2;

    // wrap-around successor of an index inside a ring of n entries
    function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
        return (idx + 1) % n;
    endfunction
endpackage

// File: rtl/cao_class_rr.sv
module cao_class_rr #(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] ptr_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    int unsigned cand;

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        cand  = 0;
        for (int k = 0; k < int'(N); k++) begin
            cand = (int'(ptr_i) + k) % N;
            if (!any_o && req_i[cand]) begin
                any_o = 1'b1;
                idx_o = IW'(cand);
            end
        end
    end

    // winner of a class is always one of its requesters
    p_class_winner_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> req_i[idx_o]);
    p_class_any_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> any_o);
endmodule

// File: rtl/cao_dir_rank.sv
module cao_dir_rank #(
    parameter int unsigned ND = 4,
    parameter int unsigned CW = 2,
    parameter int unsigned DW = (ND > 1) ? $clog2(ND) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ND-1:0]   has_i,
    input  logic [ND*CW-1:0] cong_i,
    input  logic [DW-1:0]   ptr_i,
    output logic            valid_o,
    output logic [DW-1:0]   sel_o
);
    int unsigned d;
    logic [CW-1:0] best_lvl;

    always_comb begin
        valid_o  = 1'b0;
        sel_o    = '0;
        best_lvl = '0;
        d        = 0;
        // scan in round-robin order; strict less keeps the earliest among ties
        for (int k = 0; k < int'(ND); k++) begin
            d = (int'(ptr_i) + k) % ND;
            if (has_i[d] && (!valid_o || cong_i[d*CW +: CW] < best_lvl)) begin
                valid_o  = 1'b1;
                sel_o    = DW'(d);
                best_lvl = cong_i[d*CW +: CW];
            end
        end
    end

    p_dir_pick_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> has_i[sel_o]);
    p_dir_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|has_i) |-> valid_o);
endmodule

// File: rtl/cong_out_arb.sv
module cong_out_arb
    import cong_arb_pkg::*;
#(
    parameter int unsigned NUM_VC  = DEF_NUM_VC,
    parameter int unsigned NUM_DIR = DEF_NUM_DIR,
    parameter int unsigned CONG_W  = DEF_CONG_W,
    parameter int unsigned DIR_W   = (NUM_DIR > 1) ? $clog2(NUM_DIR) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_VC-1:0]         vc_alloc_i,
    input  logic [NUM_VC-1:0]         vc_nonempty_i,
    input  logic [NUM_VC-1:0]         vc_credit_i,
    input  logic [NUM_VC-1:0]         vc_tail_i,
    input  logic [NUM_VC*DIR_W-1:0]   vc_ndir_i,
    input  logic [NUM_DIR*CONG_W-1:0] dir_cong_i,
    output logic [NUM_VC-1:0]         grant_o
);
    localparam int unsigned IW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;

    typedef struct packed {
        logic                          lock_v;
        logic [IW-1:0]                 lock_vc;
        logic [NUM_DIR-1:0][IW-1:0]    rr;
        logic [DIR_W-1:0]              dptr;
    } arb_state_t;

    arb_state_t st_q, st_d;

    logic [NUM_VC-1:0]             elig;
    logic [NUM_DIR-1:0][NUM_VC-1:0] cls_req;
    logic [NUM_DIR-1:0]            cls_any;
    logic [NUM_DIR-1:0][IW-1:0]    cls_idx;
    logic                          dir_valid;
    logic [DIR_W-1:0]              dir_sel;
    logic                          lock_hit;
    logic                          grant_any;
    logic [IW-1:0]                 grant_vc;
    logic [DIR_W-1:0]              grant_dir;

    assign elig = vc_alloc_i & vc_nonempty_i & vc_credit_i;

    for (genvar gd = 0; gd < NUM_DIR; gd++) begin : g_class
        for (genvar gv = 0; gv < NUM_VC; gv++) begin : g_member
            assign cls_req[gd][gv] = elig[gv] && (vc_ndir_i[gv*DIR_W +: DIR_W] == DIR_W'(gd));
        end
        cao_class_rr #(.N(NUM_VC), .IW(IW)) u_class_rr (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (cls_req[gd]),
            .ptr_i (st_q.rr[gd]),
            .any_o (cls_any[gd]),
            .idx_o (cls_idx[gd])
        );
    end

    cao_dir_rank #(.ND(NUM_DIR), .CW(CONG_W), .DW(DIR_W)) u_dir_rank (
        .clk     (clk),
        .rst_n   (rst_n),
        .has_i   (cls_any),
        .cong_i  (dir_cong_i),
        .ptr_i   (st_q.dptr),
        .valid_o (dir_valid),
        .sel_o   (dir_sel)
    );

    always_comb begin
        st_d      = st_q;
        lock_hit  = st_q.lock_v && elig[st_q.lock_vc];
        grant_any = lock_hit || dir_valid;
        grant_vc  = lock_hit ? st_q.lock_vc : cls_idx[dir_sel];
        grant_dir = vc_ndir_i[grant_vc*DIR_W +: DIR_W];
        grant_o   = '0;
        if (grant_any) begin
            grant_o[grant_vc]    = 1'b1;
            st_d.rr[grant_dir]   = IW'(ring_next(int'(grant_vc), NUM_VC));
            st_d.dptr            = DIR_W'(ring_next(int'(grant_dir), NUM_DIR));
            st_d.lock_v          = !vc_tail_i[grant_vc];
            st_d.lock_vc         = grant_vc;
        end else begin
            st_d.lock_v          = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    p_grant_when_work_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |-> (|grant_o));
    p_grant_only_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~(vc_alloc_i & vc_nonempty_i & vc_credit_i)) == '0);
    p_wormhole_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && ((grant_o & vc_tail_i) == '0)) |=>
        ((($past(grant_o) & elig) == '0) || (grant_o == $past(grant_o))));
endmodule

// File: tb/cong_out_arb_tb.sv
`timescale 1ns/1ps
module cong_out_arb_tb;
    localparam int NV = 16;
    localparam int ND = 4;
    localparam int CW = 2;
    localparam int DW = 2;
    localparam time CLK_P = 8ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NV-1:0] vc_alloc, vc_nonempty, vc_credit, vc_tail;
    logic [NV*DW-1:0] vc_ndir;
    logic [ND*CW-1:0] dir_cong;
    logic [NV-1:0] grant;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_lock, m_lockvc, m_dptr;
    int m_rr[ND];

    always #(CLK_P/2) clk = ~clk;

    cong_out_arb u_dut (
        .clk(clk), .rst_n(rst_n),
        .vc_alloc_i(vc_alloc), .vc_nonempty_i(vc_nonempty), .vc_credit_i(vc_credit),
        .vc_tail_i(vc_tail), .vc_ndir_i(vc_ndir), .dir_cong_i(dir_cong),
        .grant_o(grant)
    );

    function automatic int ndir_of(int v);
        return int'(vc_ndir[v*DW +: DW]);
    endfunction

    function automatic int lvl_of(int d);
        return int'(dir_cong[d*CW +: CW]);
    endfunction

    function automatic bit is_elig(int v);
        return vc_alloc[v] && vc_nonempty[v] && vc_credit[v];
    endfunction

    function automatic int model_pick();
        int best;
        if (m_lock != 0 && is_elig(m_lockvc)) return m_lockvc;
        best = -1;
        for (int k = 0; k < ND; k++) begin
            int d;
            bit has;
            d = (m_dptr + k) % ND;
            has = 0;
            for (int v = 0; v < NV; v++) if (is_elig(v) && ndir_of(v) == d) has = 1;
            if (has && (best < 0 || lvl_of(d) < lvl_of(best))) best = d;
        end
        if (best < 0) return -1;
        for (int k = 0; k < NV; k++) begin
            int v;
            v = (m_rr[best] + k) % NV;
            if (is_elig(v) && ndir_of(v) == best) return v;
        end
        return -1;
    endfunction

    task automatic model_reset();
        m_lock = 0; m_lockvc = 0; m_dptr = 0;
        for (int d = 0; d < ND; d++) m_rr[d] = 0;
    endtask

    task automatic model_commit(int g);
        if (g >= 0) begin
            m_rr[ndir_of(g)] = (g + 1) % NV;
            m_dptr = (ndir_of(g) + 1) % ND;
            m_lock = vc_tail[g] ? 0 : 1;
            m_lockvc = g;
        end else begin
            m_lock = 0;
        end
    endtask

    task automatic compare(string req, int g);
        logic [NV-1:0] exp_g;
        exp_g = '0;
        if (g >= 0) exp_g[g] = 1'b1;
        n_cmp++;
        if (grant !== exp_g) begin
            n_bad++;
            $display("FAIL %s: grant actual %b expected %b at %0t", req, grant, exp_g, $time);
        end
    endtask

    // one cycle: drive after the rising edge, check at the falling edge
    task automatic cycle(string req);
        int g;
        @(negedge clk);
        g = model_pick();
        compare(req, g);
        if (rst_n) model_commit(g);
        @(posedge clk);
        #1;
    endtask

    task automatic drive_rand(int p_elig, int cmode, int p_tail, int p_stall);
        int eq;
        eq = $urandom_range(0, 3);
        for (int v = 0; v < NV; v++) begin
            vc_alloc[v]    = ($urandom_range(0, 99) < p_elig);
            vc_nonempty[v] = ($urandom_range(0, 99) >= p_stall);
            vc_credit[v]   = ($urandom_range(0, 99) >= p_stall);
            vc_tail[v]     = ($urandom_range(0, 99) < p_tail);
            vc_ndir[v*DW +: DW] = DW'($urandom_range(0, ND-1));
        end
        for (int d = 0; d < ND; d++)
            dir_cong[d*CW +: CW] = (cmode == 1) ? CW'(eq) : CW'($urandom_range(0, 3));
    endtask

    task automatic drive_all(logic on, int dir, int lvl);
        vc_alloc = {NV{on}}; vc_nonempty = {NV{on}}; vc_credit = {NV{on}};
        vc_tail = '1;
        for (int v = 0; v < NV; v++) vc_ndir[v*DW +: DW] = DW'(dir);
        for (int d = 0; d < ND; d++) dir_cong[d*CW +: CW] = CW'(lvl);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        drive_all(1'b0, 0, 0);
        // R8: reset state, no eligible VC gives zero grant
        repeat (2) @(posedge clk);
        #1;
        cycle("R8");
        rst_n = 1'b1;
        // R8: first grant after reset with all VCs in class 0 is VC 0
        drive_all(1'b1, 0, 1);
        cycle("R8");
        // R3: rotation inside one class, all tails, 16 grants walk the ring
        for (int i = 0; i < 20; i++) cycle("R3");
        // R1: nothing eligible gives zero grant
        drive_all(1'b0, 0, 0);
        cycle("R1");
        // R2: missing any one qualifier blocks the VC
        for (int i = 0; i < 300; i++) begin drive_rand(60, 0, 100, 40); cycle("R2"); end
        // R4: mixed congestion levels, single-flit packets
        for (int i = 0; i < 400; i++) begin drive_rand(70, 0, 100, 0); cycle("R4"); end
        // R5: equal levels across directions
        for (int i = 0; i < 400; i++) begin drive_rand(70, 1, 100, 0); cycle("R5"); end
        // R6: long packets, hold across cycles with other contenders present
        for (int i = 0; i < 400; i++) begin drive_rand(80, 0, 10, 0); cycle("R6"); end
        // R7: frequent tails and stalls release the hold
        for (int i = 0; i < 400; i++) begin drive_rand(70, 0, 40, 25); cycle("R7"); end
        // R1: broad random traffic
        for (int i = 0; i < 400; i++) begin drive_rand($urandom_range(0, 100), 0, 30, 10); cycle("R1"); end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule